// File: doc/BRIEF.md
# Multi-Lane Wildcard Payload Scanner

This block checks the bytes of each packet against a fixed set of patterns. It produces one bitmap per packet, with one bit for each pattern. A pattern is made of elements, and each element is one of four kinds:

- a literal byte;
- a choice between two bytes, written `{x|y}`;
- `?`, which stands for exactly one byte of any value;
- `*`, which stands for a run of any bytes of any length, including zero.

The patterns are set when the design is elaborated. A pattern may match starting at any byte of the packet.

Each matcher keeps the set of every prefix of its pattern that is currently matched. It updates this set once for each byte, so it never backtracks. The block has several identical lanes, and each lane holds one matcher per pattern.

Packets arrive as a byte stream framed by start and end flags, with a valid/ready handshake. At the first byte of a packet, the dispatcher hands the packet to the lowest-numbered idle lane, and that lane receives every byte of the packet. The collector keeps a ticket for each lane in the order packets arrived. It releases the results only in that order, through a valid/ready output, and it reports which lane did the work. A lane is busy from its first byte until its result has been taken at the output.

Top module: `payload_scan`

## Requirements
- R1: Pattern bit p of a result is 1 when some run of consecutive bytes in the packet matches pattern p. The run may start at any offset, and a literal element accepts only its own byte.
- R2: A `?` element consumes exactly one byte of any value. For example, `x?z` matches "xAz" but not "xz".
- R3: A `*` element consumes zero or more bytes of any value. For example, `ab*cd` matches both "abcd" and "abXYZcd".
- R4: A `{x|y}` element accepts either of the two listed bytes and no other byte.
- R5: Matching state and match bits start fresh with every packet. A prefix seen at the end of one packet never combines with bytes of the next packet, and a bit that has been set stays set until the packet's result has been delivered.
- R6: Each packet yields exactly one result. Bit p of `out_match` belongs to pattern p. The default set, with its bit positions, is:

  | Bit | Pattern |
  |---|---|
  | 0 | `{A|a}ll` |
  | 1 | `x?z` |
  | 2 | `ab*cd` |
  | 3 | `*Q` |
  | 4 | `HI*` |
  | 5 | `{0|1}{0|1}?` |
  | 6 | `spam` |
  | 7 | `k??k` |

- R7: Each new packet goes to the lowest-numbered idle lane, and `out_lane` shows that lane number alongside the packet's result.
- R8: `in_ready` is 1 while a packet is in progress. Between packets, `in_ready` is 1 only when at least one lane is idle. A byte is accepted only when `in_valid` and `in_ready` are both 1.
- R9: Results leave in packet arrival order. A result becomes valid on the cycle after its last byte is accepted. While `out_ready` is 0, `out_valid`, `out_match` and `out_lane` stay stable.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_sop | input | 1 | Byte is the first byte of a packet |
| in_eop | input | 1 | Byte is the last byte of a packet |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Scanner can accept the byte |
| out_valid | output | 1 | Result bitmap is valid |
| out_match | output | 8 | One bit per pattern |
| out_lane | output | clog2(LANES) | Lane that scanned the packet |
| out_ready | input | 1 | Consumer takes the result |

## Verification
The collector can release the head lane in the same cycle that the dispatcher admits the first byte of a new packet. The freed lane must not become eligible until the following cycle.

To provoke this, the bench holds `out_ready` low until every lane is full and `in_ready` has dropped while packets are still queued, then opens the output again. After that it keeps `in_valid` and `out_ready` switching at random, so that pushes and pops land on the same edge.

On every cycle, a behavioural model compares `in_ready`, the lane choice and the order of the results. It also computes each match bit by an anchored search from every start offset.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int NPAT = 8;   // number of patterns
    localparam int MAXE = 8;   // longest pattern, in elements

    typedef enum logic [1:0] {EK_LIT, EK_ALT, EK_ONE, EK_RUN} ekind_t;

    typedef struct packed {
        ekind_t     kind;
        logic [7:0] b0;
        logic [7:0] b1;
    } elem_t;

    typedef enum logic [1:0] {LS_IDLE, LS_RECV, LS_DONE} lstate_t;

    function automatic elem_t e_lit(input logic [7:0] c);
        return '{kind: EK_LIT, b0: c, b1: c};
    endfunction

    function automatic elem_t e_alt(input logic [7:0] c0, input logic [7:0] c1);
        return '{kind: EK_ALT, b0: c0, b1: c1};
    endfunction

    function automatic elem_t e_one();
        return '{kind: EK_ONE, b0: 8'h00, b1: 8'h00};
    endfunction

    function automatic elem_t e_run();
        return '{kind: EK_RUN, b0: 8'h00, b1: 8'h00};
    endfunction

    function automatic int pat_len(input int p);
        case (p)
            0: return 3;
            1: return 3;
            2: return 5;
            3: return 2;
            4: return 3;
            5: return 3;
            6: return 4;
            default: return 4;
        endcase
    endfunction

    function automatic elem_t pat_elem(input int p, input int i);
        elem_t e;
        e = e_lit(8'h00);
        case (p)
            0: case (i)
                   0: e = e_alt("A", "a");
                   1: e = e_lit("l");
                   2: e = e_lit("l");
                   default: ;
               endcase
            1: case (i)
                   0: e = e_lit("x");
                   1: e = e_one();
                   2: e = e_lit("z");
                   default: ;
               endcase
            2: case (i)
                   0: e = e_lit("a");
                   1: e = e_lit("b");
                   2: e = e_run();
                   3: e = e_lit("c");
                   4: e = e_lit("d");
                   default: ;
               endcase
            3: case (i)
                   0: e = e_run();
                   1: e = e_lit("Q");
                   default: ;
               endcase
            4: case (i)
                   0: e = e_lit("H");
                   1: e = e_lit("I");
                   2: e = e_run();
                   default: ;
               endcase
            5: case (i)
                   0: e = e_alt("0", "1");
                   1: e = e_alt("0", "1");
                   2: e = e_one();
                   default: ;
               endcase
            6: case (i)
                   0: e = e_lit("s");
                   1: e = e_lit("p");
                   2: e = e_lit("a");
                   3: e = e_lit("m");
                   default: ;
               endcase
            default: case (i)
                   0: e = e_lit("k");
                   1: e = e_one();
                   2: e = e_one();
                   3: e = e_lit("k");
                   default: ;
               endcase
        endcase
        return e;
    endfunction

    function automatic logic elem_accepts(input elem_t e, input logic [7:0] c);
        if (e.kind == EK_ONE || e.kind == EK_RUN) return 1'b1;
        return (c == e.b0) || (c == e.b1);
    endfunction

endpackage

// File: rtl/scan_engine.sv
module scan_engine
    import scan_pkg::*;
#(
    parameter int PAT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       beat,
    input  logic       sop,
    input  logic [7:0] data,
    output logic       matched
);
    localparam int LEN = pat_len(PAT);

    // bit k set: first k elements matched ending at the latest byte
    logic [LEN:0] raw_q;
    logic [LEN:0] act;
    logic [LEN:0] nxt;
    logic         hit;
    logic         matched_q;

    always_comb begin
        elem_t e;
        e   = e_lit(8'h00);
        act = sop ? '0 : raw_q;
        act[0] = 1'b1;
        // a run element may be skipped: carry activity past it
        for (int k = 0; k < LEN; k++) begin
            e = pat_elem(PAT, k);
            if (e.kind == EK_RUN && act[k]) act[k+1] = 1'b1;
        end
        nxt = '0;
        for (int k = 0; k < LEN; k++) begin
            e = pat_elem(PAT, k);
            if (e.kind == EK_RUN) begin
                if (act[k]) nxt[k] = 1'b1;
            end else if (act[k] && elem_accepts(e, data)) begin
                nxt[k+1] = 1'b1;
            end
        end
        for (int k = 0; k < LEN; k++) begin
            e = pat_elem(PAT, k);
            if (e.kind == EK_RUN && nxt[k]) nxt[k+1] = 1'b1;
        end
        hit = beat && nxt[LEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            matched_q <= 1'b0;
        end else if (beat) begin
            raw_q     <= nxt;
            matched_q <= (sop ? 1'b0 : matched_q) | hit;
        end
    end

    assign matched = matched_q;

    // R5
    fresh_packet_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && sop && !hit) |=> !matched)
        else $error("match bit carried into a new packet");

endmodule

// File: rtl/scan_lane.sv
module scan_lane
    import scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            beat,
    input  logic            sop,
    input  logic            eop,
    input  logic [7:0]      data,
    input  logic            free,
    output logic            idle,
    output logic            done,
    output logic [NPAT-1:0] match_vec
);
    lstate_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LS_IDLE;
        end else begin
            case (st_q)
                LS_IDLE: if (beat) st_q <= eop ? LS_DONE : LS_RECV;
                LS_RECV: if (beat && eop) st_q <= LS_DONE;
                LS_DONE: if (free) st_q <= LS_IDLE;
                default: st_q <= LS_IDLE;
            endcase
        end
    end

    assign idle = (st_q == LS_IDLE);
    assign done = (st_q == LS_DONE);

    for (genvar p = 0; p < NPAT; p++) begin : g_eng
        scan_engine #(.PAT(p)) u_eng (
            .clk    (clk),
            .rst    (rst),
            .beat   (beat),
            .sop    (sop),
            .data   (data),
            .matched(match_vec[p])
        );
    end

    // R9
    no_beat_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !beat)
        else $error("byte steered into a finished lane");

endmodule

// File: rtl/scan_order_fifo.sv
module scan_order_fifo #(
    parameter  int DEPTH = 4,
    parameter  int W     = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (cnt_q < CW'(DEPTH)))
        else $error("ticket queue overflow");

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0))
        else $error("ticket queue underflow");

endmodule

// File: rtl/payload_scan.sv
module payload_scan
    import scan_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic            out_valid,
    output logic [NPAT-1:0] out_match,
    output logic [LW-1:0]   out_lane,
    input  logic            out_ready
);
    logic [LANES-1:0] lane_idle, lane_done, lane_beat, lane_free;
    logic [NPAT-1:0]  lane_match [LANES];
    logic             in_pkt_q;
    logic [LW-1:0]    cur_q, pick, sel, head;
    logic             any_idle, accept, start, pop, fifo_empty;

    // dispatcher: lowest idle lane
    always_comb begin
        pick = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_idle[i]) pick = LW'(i);
        end
    end

    assign any_idle = |lane_idle;
    assign in_ready = in_pkt_q | any_idle;
    assign accept   = in_valid & in_ready;
    assign start    = accept & ~in_pkt_q;
    assign sel      = in_pkt_q ? cur_q : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q <= 1'b0;
            cur_q    <= '0;
        end else if (accept) begin
            in_pkt_q <= ~in_eop;
            if (start) cur_q <= pick;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_beat[i] = accept && (sel == LW'(i));
        assign lane_free[i] = pop && (head == LW'(i));
        scan_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .beat     (lane_beat[i]),
            .sop      (~in_pkt_q),
            .eop      (in_eop),
            .data     (in_data),
            .free     (lane_free[i]),
            .idle     (lane_idle[i]),
            .done     (lane_done[i]),
            .match_vec(lane_match[i])
        );
    end

    // collector: tickets in arrival order
    scan_order_fifo #(.DEPTH(LANES), .W(LW)) u_order (
        .clk  (clk),
        .rst  (rst),
        .push (start),
        .din  (pick),
        .pop  (pop),
        .head (head),
        .empty(fifo_empty)
    );

    assign out_valid = !fifo_empty && lane_done[head];
    assign pop       = out_valid & out_ready;
    assign out_match = lane_match[head];
    assign out_lane  = head;

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_beat & lane_idle))
        else $error("more than one lane granted");

    // R8
    framing_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (in_sop == !in_pkt_q))
        else $error("start flag disagrees with packet framing");

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_match) && $stable(out_lane)))
        else $error("result changed while stalled");

endmodule

// File: tb/tb_payload_scan.sv
module tb_payload_scan;
    localparam int CLK_NS = 10;
    localparam int LANES  = 4;
    localparam int NP     = 8;
    localparam int LW     = 2;
    localparam int LIMIT  = 20000;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_sop, in_eop, in_ready;
    logic [7:0] in_data;
    logic out_valid, out_ready;
    logic [NP-1:0] out_match;
    logic [LW-1:0] out_lane;

    always #(CLK_NS / 2) clk = ~clk;

    payload_scan #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_match(out_match), .out_lane(out_lane), .out_ready(out_ready)
    );

    int nvec = 0;
    int nerr = 0;

    // pattern table parsed from text
    string pats[NP] = '{"{A|a}ll", "x?z", "ab*cd", "*Q", "HI*", "{0|1}{0|1}?", "spam", "k??k"};
    int         plen[NP];
    int         pkind[NP][8];   // 0 byte choice, 2 single wildcard, 3 run
    logic [7:0] pa[NP][8];
    logic [7:0] pb[NP][8];

    // stimulus beats {sop, eop, data}
    logic [9:0] beats[$];

    // model state
    int         q_lane[$];
    bit         q_done[$];
    logic [7:0] q_match[$];
    bit         idle_m[LANES];
    bit         inpkt_m;
    int         cur_m;
    logic [7:0] cb[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic parse_pats();
        for (int p = 0; p < NP; p++) begin
            int i;
            int n;
            i = 0;
            n = 0;
            while (i < pats[p].len()) begin
                logic [7:0] c;
                c = pats[p].getc(i);
                if (c == "{") begin
                    pkind[p][n] = 0;
                    pa[p][n] = pats[p].getc(i + 1);
                    pb[p][n] = pats[p].getc(i + 3);
                    i += 5;
                end else if (c == "?") begin
                    pkind[p][n] = 2; i++;
                end else if (c == "*") begin
                    pkind[p][n] = 3; i++;
                end else begin
                    pkind[p][n] = 0; pa[p][n] = c; pb[p][n] = c; i++;
                end
                n++;
            end
            plen[p] = n;
        end
    endtask

    task automatic add_pkt(input string s);
        for (int i = 0; i < s.len(); i++) begin
            logic [7:0] c;
            c = s.getc(i);
            beats.push_back({(i == 0), (i == s.len() - 1), c});
        end
    endtask

    // anchored search from each start offset of the current packet
    function automatic bit pat_hit(input int p);
        int n;
        n = plen[p];
        for (int s = 0; s < cb.size(); s++) begin
            bit st[9];
            bit nx[9];
            for (int k = 0; k < 9; k++) st[k] = 0;
            st[0] = 1;
            for (int k = 0; k < n; k++) if (pkind[p][k] == 3 && st[k]) st[k+1] = 1;
            for (int j = s; j < cb.size(); j++) begin
                bit any;
                any = 0;
                for (int k = 0; k < 9; k++) nx[k] = 0;
                for (int k = 0; k < n; k++) begin
                    if (st[k]) begin
                        if (pkind[p][k] == 3) nx[k] = 1;
                        else if (pkind[p][k] == 2) nx[k+1] = 1;
                        else if (cb[j] == pa[p][k] || cb[j] == pb[p][k]) nx[k+1] = 1;
                    end
                end
                for (int k = 0; k < n; k++) if (pkind[p][k] == 3 && nx[k]) nx[k+1] = 1;
                if (nx[n]) return 1;
                for (int k = 0; k < 9; k++) begin
                    st[k] = nx[k];
                    if (nx[k]) any = 1;
                end
                if (!any) break;
            end
        end
        return 0;
    endfunction

    initial begin
        string alpha;
        bit exp_ready, exp_ov;
        int cyc;
        alpha = "AalxzbcdQHI01spmk";
        parse_pats();
        // directed packets
        add_pkt("Allx");        // R4 upper choice, R1
        add_pkt("aLL");         // R4 no other byte
        add_pkt("xAz");         // R2
        add_pkt("xz");          // R2 needs one byte
        add_pkt("abcd");        // R3 empty run
        add_pkt("abXYZcd");     // R3 long run
        add_pkt("Q");           // single-byte packet
        add_pkt("HI");          // trailing run
        add_pkt("ab");          // R5 then next packet must not match
        add_pkt("cd");
        add_pkt("spaspam");     // R1 restart at offset
        add_pkt("01x");
        add_pkt("k12k");
        add_pkt("kk");
        for (int n = 0; n < 150; n++) begin
            int len;
            string s;
            len = 1 + ($urandom % 12);
            s = "";
            for (int i = 0; i < len; i++) begin
                string one;
                one = " ";
                one.putc(0, alpha.getc($urandom % alpha.len()));
                s = {s, one};
            end
            add_pkt(s);
        end

        for (int i = 0; i < LANES; i++) idle_m[i] = 1;
        inpkt_m = 0;
        cur_m = 0;
        rst = 1; in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0; out_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(in_ready === 1'b1, "R10", 32'(in_ready), 1);
        chk(out_valid === 1'b0, "R10", 32'(out_valid), 0);

        cyc = 0;
        while (cyc < LIMIT && (beats.size() > 0 || q_lane.size() > 0)) begin
            int pick;
            // expected outputs for this cycle
            exp_ready = inpkt_m;
            for (int i = 0; i < LANES; i++) if (idle_m[i]) exp_ready = 1;
            exp_ov = (q_lane.size() > 0) && q_done[0];
            chk(in_ready === exp_ready, "R8", 32'(in_ready), 32'(exp_ready));
            chk(out_valid === exp_ov, "R9", 32'(out_valid), 32'(exp_ov));
            if (exp_ov) begin
                chk(out_lane === LW'(q_lane[0]), "R7", 32'(out_lane), 32'(q_lane[0]));
                chk(out_match === q_match[0], "R1/R2/R3/R4/R5/R6", 32'(out_match), 32'(q_match[0]));
            end
            // drive
            if (cyc >= 60 && cyc < 110) out_ready = 0;
            else if (cyc >= 200) out_ready = ($urandom % 3) != 0;
            else out_ready = 1;
            in_valid = (beats.size() > 0) && ((cyc < 200) || (($urandom % 4) != 0));
            if (in_valid) {in_sop, in_eop, in_data} = beats[0];
            else {in_sop, in_eop, in_data} = '0;
            @(posedge clk);
            // model update
            pick = 0;
            for (int i = LANES - 1; i >= 0; i--) if (idle_m[i]) pick = i;
            if (out_ready && exp_ov) begin
                idle_m[q_lane[0]] = 1;
                void'(q_lane.pop_front());
                void'(q_done.pop_front());
                void'(q_match.pop_front());
            end
            if (in_valid && exp_ready) begin
                if (!inpkt_m) begin
                    cur_m = pick;
                    idle_m[pick] = 0;
                    q_lane.push_back(pick);
                    q_done.push_back(0);
                    q_match.push_back(8'h00);
                    cb.delete();
                end
                cb.push_back(in_data);
                if (in_eop) begin
                    logic [7:0] v;
                    for (int p = 0; p < NP; p++) v[p] = pat_hit(p);
                    q_done[q_done.size() - 1] = 1;
                    q_match[q_match.size() - 1] = v;
                    inpkt_m = 0;
                end else begin
                    inpkt_m = 1;
                end
                void'(beats.pop_front());
            end
            @(negedge clk);
            cyc++;
        end
        if (beats.size() > 0 || q_lane.size() > 0) begin
            nerr++;
            nvec++;
            $display("FAIL R9: watchdog, %0d beats and %0d results pending", beats.size(), q_lane.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule